// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block sits on one side of a dual-port data path whose 36-bit words are cut into four 9-bit lanes. In each lane the eight low bits carry data and the top bit carries parity. The block watches the inbound bus and drives an active-low error flag whenever any lane breaks the selected parity sense. A single select input picks odd or even parity for both checking and generation.

On the read side, the block can replace each lane's stored top bit with a parity bit it computes from that lane's eight data bits. The stored word itself is never altered. Two read sources are served:

- A mailbox word is read combinationally. Its parity is produced by the same tree set that checks the inbound bus. While that shared tree set is busy generating for a mailbox read, the error flag is forced inactive.
- A FIFO word passes through its own tree before it is captured in an output register. The generate and sense selects are sampled on the loading edge.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k occupies bits 9k to 9k+8, and bit 9k+8 is its parity bit. Generation changes only the parity bits and leaves every data bit as it was.
- R2: With `odd_sel` = 1, `perr_n` is 0 when at least one lane holds an even number of ones, and 1 otherwise.
- R3: With `odd_sel` = 0, `perr_n` is 0 when at least one lane holds an odd number of ones, and 1 otherwise.
- R4: `perr_n` follows `bus_in` and `odd_sel` in the same cycle, with no clock edge in between.
- R5: While `rd_req`, `mb_sel` and `gen_en` are all 1, `perr_n` is 1 whatever `bus_in` carries.
- R6: While `rd_req`, `mb_sel` and `gen_en` are all 1, `rd_data` equals `mbox_word` except for each lane's parity bit. That bit is generated from the lane's data bits so that the lane holds an odd number of ones when `odd_sel` = 1, and an even number when `odd_sel` = 0.
- R7: While `mb_sel` is 1 and either `rd_req` or `gen_en` is 0, `rd_data` equals `mbox_word` bit for bit.
- R8: A clock edge with `fifo_load` = 1 captures `fifo_word` into the output register, with generated parity bits (rule of R6) if `gen_en` = 1 and unchanged if `gen_en` = 0. While `mb_sel` is 0, `rd_data` shows that register from the following cycle.
- R9: Changes to `gen_en` or `odd_sel` after the loading edge do not alter the FIFO word shown on `rd_data`.
- R10: Without `fifo_load`, the output register keeps its value across clock edges.
- R11: While `rst_n` is 0, the output register is cleared, so `rd_data` is 0 when `mb_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the FIFO output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| gen_en | input | 1 | Enables parity generation on reads |
| rd_req | input | 1 | Port read is selected this cycle |
| mb_sel | input | 1 | Read path source: 1 mailbox, 0 FIFO register |
| bus_in | input | 36 | Inbound port bus to be checked |
| mbox_word | input | 36 | Stored mailbox word being read out |
| fifo_word | input | 36 | Word just read from FIFO memory |
| fifo_load | input | 1 | Loads the FIFO output register on this edge |
| rd_data | output | 36 | Outgoing read word |
| perr_n | output | 1 | Active-low combined lane parity error flag |

## Verification
The bench builds the block with two lanes of three data bits each, so a whole bus word is eight bits. This lets every bus value be swept under both parity senses.

Each value is applied as inbound data, as a mailbox word with and without generation, and as a FIFO word loaded with the generate select on or off. Expected flags and words are counted out lane by lane in the bench. This brings the multi-lane error combination, the shared-tree override and the capture-time sampling of the selects fully within reach.

// File: rtl/lane_par_pkg.sv
package lane_par_pkg;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } par_sense_e;

    // parity bit that completes a lane whose data bits reduce to data_xor
    function automatic logic fill_bit(input logic data_xor, input par_sense_e sense);
        return (sense == SENSE_ODD) ? ~data_xor : data_xor;
    endfunction

    // lane violates the sense when the full lane reduces to full_xor
    function automatic logic lane_bad(input logic full_xor, input par_sense_e sense);
        return (sense == SENSE_ODD) ? ~full_xor : full_xor;
    endfunction

endpackage

// File: rtl/lane_par_tree.sv
module lane_par_tree #(
    parameter int LANES     = 4,
    parameter int DATA_BITS = 8
) (
    input  logic [LANES*(DATA_BITS+1)-1:0] word_i,
    output logic [LANES-1:0]               data_xor_o
);
    localparam int LW = DATA_BITS + 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            data_xor_o[l] = ^word_i[l*LW +: DATA_BITS];
        end
    end
endmodule

// File: rtl/lane_par_subst.sv
module lane_par_subst #(
    parameter int LANES     = 4,
    parameter int DATA_BITS = 8
) (
    input  logic [LANES*(DATA_BITS+1)-1:0] word_i,
    input  logic [LANES-1:0]               data_xor_i,
    input  logic                           sense_i,
    input  logic                           gen_i,
    output logic [LANES*(DATA_BITS+1)-1:0] word_o
);
    import lane_par_pkg::*;
    localparam int LW = DATA_BITS + 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            word_o[l*LW +: DATA_BITS] = word_i[l*LW +: DATA_BITS];
            word_o[l*LW + DATA_BITS]  = gen_i ? fill_bit(data_xor_i[l], par_sense_e'(sense_i))
                                              : word_i[l*LW + DATA_BITS];
        end
    end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
    parameter int LANES     = 4,
    parameter int DATA_BITS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           odd_sel,
    input  logic                           gen_en,
    input  logic                           rd_req,
    input  logic                           mb_sel,
    input  logic [LANES*(DATA_BITS+1)-1:0] bus_in,
    input  logic [LANES*(DATA_BITS+1)-1:0] mbox_word,
    input  logic [LANES*(DATA_BITS+1)-1:0] fifo_word,
    input  logic                           fifo_load,
    output logic [LANES*(DATA_BITS+1)-1:0] rd_data,
    output logic                           perr_n
);
    import lane_par_pkg::*;

    localparam int LW = DATA_BITS + 1;
    localparam int W  = LANES * LW;

    typedef struct packed {
        logic [W-1:0] fifo_out;
    } state_t;

    state_t state_d, state_q;

    logic             mbox_gen;
    logic [W-1:0]     shared_src;
    logic [LANES-1:0] shared_xor;
    logic [LANES-1:0] lane_fail;
    logic [W-1:0]     mbox_path;
    logic [LANES-1:0] fifo_xor;
    logic [W-1:0]     fifo_path;

    // shared tree: generates for a mailbox read, otherwise checks the bus
    assign mbox_gen   = rd_req & mb_sel & gen_en;
    assign shared_src = mbox_gen ? mbox_word : bus_in;

    lane_par_tree #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_shared_tree (
        .word_i     (shared_src),
        .data_xor_o (shared_xor)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_check
        always_comb begin
            lane_fail[l] = lane_bad(shared_xor[l] ^ bus_in[l*LW + DATA_BITS],
                                    par_sense_e'(odd_sel));
        end
    end

    lane_par_subst #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_mbox_subst (
        .word_i     (mbox_word),
        .data_xor_i (shared_xor),
        .sense_i    (odd_sel),
        .gen_i      (mbox_gen),
        .word_o     (mbox_path)
    );

    // dedicated tree between memory read and output register
    lane_par_tree #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_fifo_tree (
        .word_i     (fifo_word),
        .data_xor_o (fifo_xor)
    );

    lane_par_subst #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_fifo_subst (
        .word_i     (fifo_word),
        .data_xor_i (fifo_xor),
        .sense_i    (odd_sel),
        .gen_i      (gen_en),
        .word_o     (fifo_path)
    );

    always_comb begin
        state_d = state_q;
        if (fifo_load) begin
            state_d.fifo_out = fifo_path;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = mb_sel ? mbox_path : state_q.fifo_out;
    assign perr_n  = mbox_gen | ~(|lane_fail);

endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk #(
    parameter int LANES     = 4,
    parameter int DATA_BITS = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           odd_sel,
    input logic                           gen_en,
    input logic                           rd_req,
    input logic                           mb_sel,
    input logic [LANES*(DATA_BITS+1)-1:0] bus_in,
    input logic [LANES*(DATA_BITS+1)-1:0] mbox_word,
    input logic [LANES*(DATA_BITS+1)-1:0] fifo_word,
    input logic                           fifo_load,
    input logic [LANES*(DATA_BITS+1)-1:0] rd_data,
    input logic                           perr_n
);
    localparam int LW = DATA_BITS + 1;
    localparam int W  = LANES * LW;

    function automatic logic [W-1:0] data_mask();
        logic [W-1:0] m;
        m = '1;
        for (int l = 0; l < LANES; l++) m[l*LW + DATA_BITS] = 1'b0;
        return m;
    endfunction

    localparam logic [W-1:0] DMASK = data_mask();

    assert_mbox_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mb_sel && gen_en) |-> perr_n);

    assert_mbox_data_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mb_sel |-> ((rd_data & DMASK) == (mbox_word & DMASK)));

    assert_mbox_plain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_sel && !(rd_req && gen_en)) |-> (rd_data == mbox_word));

    assert_fifo_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_load |=> (mb_sel || ((rd_data & DMASK) == ($past(fifo_word) & DMASK))));

    assert_fifo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_load && !mb_sel) |=> (mb_sel || $stable(rd_data)));

    // R1: no data bit of a loaded word may be touched by generation
    assert_data_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_load && gen_en) |=> (mb_sel || ((rd_data & DMASK) == ($past(fifo_word) & DMASK))));

endmodule

bind lane_parity_unit lane_parity_unit_chk #(.LANES(LANES), .DATA_BITS(DATA_BITS)) u_chk (.*);

// File: tb/lane_parity_unit_tb.sv
module lane_parity_unit_tb;
    localparam int LANES = 2;
    localparam int DB    = 3;
    localparam int LW    = DB + 1;
    localparam int W     = LANES * LW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         odd_sel = 1'b0, gen_en = 1'b0, rd_req = 1'b0, mb_sel = 1'b0, fifo_load = 1'b0;
    logic [W-1:0] bus_in = '0, mbox_word = '0, fifo_word = '0;
    logic [W-1:0] rd_data;
    logic         perr_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lane_parity_unit #(.LANES(LANES), .DATA_BITS(DB)) u_dut (
        .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .gen_en(gen_en),
        .rd_req(rd_req), .mb_sel(mb_sel), .bus_in(bus_in), .mbox_word(mbox_word),
        .fifo_word(fifo_word), .fifo_load(fifo_load), .rd_data(rd_data), .perr_n(perr_n)
    );

    function automatic int ones(input logic [W-1:0] v, input int lo, input int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += v[lo+i];
        return c;
    endfunction

    function automatic logic exp_perr_n(input logic [W-1:0] v, input logic odd);
        logic bad = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            int c = ones(v, l*LW, LW);
            if (odd ? (c % 2 == 0) : (c % 2 == 1)) bad = 1'b1;
        end
        return !bad;
    endfunction

    function automatic logic [W-1:0] exp_gen(input logic [W-1:0] v, input logic odd);
        logic [W-1:0] r = v;
        for (int l = 0; l < LANES; l++) begin
            int c = ones(v, l*LW, DB);
            r[l*LW + DB] = odd ? (c % 2 == 0) : (c % 2 == 1);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset clears register", rd_data, '0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R11 register zero after reset", rd_data, '0);

        for (int o = 0; o < 2; o++) begin
            for (int v = 0; v < (1 << W); v++) begin
                logic [W-1:0] w = W'(v);
                logic         g = w[0] ^ w[W-1];
                logic [W-1:0] held;

                // R2/R3/R4: inbound check, changed mid-cycle, read next delta
                @(negedge clk);
                odd_sel = o[0]; mb_sel = 1'b0; rd_req = 1'b0; gen_en = 1'b0;
                bus_in = w;
                #1;
                check(o ? "R2 odd check R4" : "R3 even check R4", {{(W-1){1'b0}}, perr_n},
                      {{(W-1){1'b0}}, exp_perr_n(w, o[0])});

                // R7: mailbox without generation
                mb_sel = 1'b1; mbox_word = w; rd_req = 1'b1; gen_en = 1'b0;
                #1;
                check("R7 mailbox plain", rd_data, w);
                rd_req = 1'b0; gen_en = 1'b1;
                #1;
                check("R7 mailbox no read", rd_data, w);

                // R5/R6/R1: mailbox read with generation; bus holds a bad word
                rd_req = 1'b1; gen_en = 1'b1; bus_in = ~exp_gen(w, ~o[0]);
                mbox_word = w;
                #1;
                check("R5 flag forced high", {{(W-1){1'b0}}, perr_n}, {{(W-1){1'b0}}, 1'b1});
                check("R6 R1 mailbox generated", rd_data, exp_gen(w, o[0]));

                // R8: FIFO capture, generation chosen by a bit of the value
                @(negedge clk);
                mb_sel = 1'b0; rd_req = 1'b0; fifo_word = w; gen_en = g; fifo_load = 1'b1;
                @(negedge clk);
                fifo_load = 1'b0;
                #1;
                held = g ? exp_gen(w, o[0]) : w;
                check("R8 fifo capture", rd_data, held);

                // R9: selects change after the loading edge
                gen_en = ~g; odd_sel = ~o[0]; fifo_word = ~w;
                #1;
                check("R9 selects sampled at load", rd_data, held);

                // R10: an edge without load keeps the word
                @(negedge clk);
                #1;
                check("R10 register holds", rd_data, held);
            end
        end

        // R11: reset mid-run clears the register again
        @(negedge clk);
        mb_sel = 1'b0; fifo_word = '1; fifo_load = 1'b1; gen_en = 1'b0;
        @(negedge clk);
        fifo_load = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R11 reset mid-run", rd_data, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule